// File: doc/BRIEF.md
# Neighbor-Based Prefetch Predictor

This block guesses where the search window of the next largest coding unit (LCU) will be centred, so that reference pixels can be requested from external memory before the left neighbour's motion search has finished. The guess uses only the motion-vector predictors of the neighbours above (top, top-right, top-left) and their availability. As soon as the top-right neighbour reports that its search is done, the block latches a predicted centre. It also computes the upper-left pixel of a search window around that centre, limited to the frame, and offers both as one request on a valid/ready channel.

Which vector is chosen depends on how many of the three neighbours are usable. With none, the centre is the zero vector. With one, that neighbour's vector is used. With two, the top neighbour wins over the top-right neighbour, and the top-right neighbour wins over the top-left one. With all three, each component is the signed median of the three vectors, taken separately for x and y. Neighbours that would lie outside the frame are never used, whatever the availability inputs say.

Top module: `pfp_top`

## Requirements
- R1: When no neighbour is usable, the request's centre is (0,0).
- R2: When exactly one neighbour is usable, the centre equals that neighbour's vector.
- R3: When exactly two neighbours are usable, the centre is the top vector if top is among them, otherwise the top-right vector.
- R4: When all three neighbours are usable, the centre x is the signed median of the three x components, and the centre y is computed the same way from the three y components.
- R5: The availability bits are nbr_avail[0]=top, nbr_avail[1]=top-right, nbr_avail[2]=top-left. In row 0 all three are treated as unusable. In column 0 the top-left one is unusable. In the last column (NCOLS-1) the top-right one is unusable.
- R6: A tr_done pulse that is accepted makes req_valid high from the next clock edge, carrying the centre and corner computed from the inputs present with the pulse.
- R7: While req_valid is high and req_ready is low, req_valid, req_x, req_y, ctr_x and ctr_y hold their values. After a handshake with no new pulse, req_valid is low from the next edge.
- R8: A tr_done pulse that arrives while a request is pending and req_ready is low is ignored. The request already pending is unchanged, and no request for that pulse is produced later.
- R9: The window corner along each axis is the LCU origin (index × LCU pixels) plus the centre component minus RANGE. The result is clamped to the range from 0 up to the frame size minus (LCU + 2×RANGE).
- R10: After reset, req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tr_done | input | 1 | One-cycle pulse: the top-right neighbour's search has finished |
| cur_col | input | COL_W | Column index of the current LCU |
| cur_row | input | ROW_W | Row index of the current LCU |
| nbr_avail | input | 3 | Availability: bit0 top, bit1 top-right, bit2 top-left |
| t_mvx | input | MV_W | Top neighbour predictor x (signed) |
| t_mvy | input | MV_W | Top neighbour predictor y (signed) |
| tr_mvx | input | MV_W | Top-right neighbour predictor x (signed) |
| tr_mvy | input | MV_W | Top-right neighbour predictor y (signed) |
| tl_mvx | input | MV_W | Top-left neighbour predictor x (signed) |
| tl_mvy | input | MV_W | Top-left neighbour predictor y (signed) |
| req_ready | input | 1 | Memory side can take the request |
| req_valid | output | 1 | Prefetch request pending |
| req_x | output | XW | Window corner x in pixels |
| req_y | output | YW | Window corner y in pixels |
| ctr_x | output | MV_W | Predicted centre x (signed) |
| ctr_y | output | MV_W | Predicted centre y (signed) |

## Verification
A pulse on tr_done is accepted at a clock edge, and the request it produces is visible one edge later. The bench therefore checks req_valid just after the edge that follows the pulse. It compares the request fields at the middle of a clock period in which valid and ready are both high, which is the period before the handshake edge. Each accepted pulse queues one expected request, computed by an independent model. While ready is held low, the bench checks stability once per cycle. After the handshake, it checks that valid has dropped one edge later. An ignored pulse queues nothing, so any extra request shows up as an unexpected pop.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  localparam int NB_T  = 0;
  localparam int NB_TR = 1;
  localparam int NB_TL = 2;

  function automatic int pfp_min(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int pfp_max(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // signed median of three
  function automatic int pfp_med3(int a, int b, int c);
    return pfp_max(pfp_min(a, b), pfp_min(pfp_max(a, b), c));
  endfunction

  // choose one component from the usable neighbours
  function automatic int pfp_pick(logic [2:0] use_nb, int t, int tr, int tl);
    case ($countones(use_nb))
      0:       return 0;
      3:       return pfp_med3(t, tr, tl);
      default: return use_nb[NB_T] ? t : (use_nb[NB_TR] ? tr : tl);
    endcase
  endfunction

  function automatic int pfp_clamp(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction
endpackage

// File: rtl/pfp_select.sv
module pfp_select
  import pfp_pkg::*;
#(
  parameter int MV_W  = 10,
  parameter int COL_W = 3,
  parameter int ROW_W = 3,
  parameter int NCOLS = 8
) (
  input  logic [COL_W-1:0]        col,
  input  logic [ROW_W-1:0]        row,
  input  logic [2:0]              avail,
  input  logic [5:0][MV_W-1:0]    mvs,     // index = neighbour*2 + component
  output logic [2:0]              use_nb,
  output logic [1:0][MV_W-1:0]    sel
);
  localparam int LAST_COL = NCOLS - 1;

  always_comb begin
    use_nb = avail;
    if (row == '0) use_nb = 3'b000;
    if (col == '0) use_nb[NB_TL] = 1'b0;
    if (int'(col) == LAST_COL) use_nb[NB_TR] = 1'b0;
  end

  for (genvar c = 0; c < 2; c++) begin : g_comp
    always_comb begin
      sel[c] = MV_W'(pfp_pick(use_nb,
                              int'($signed(mvs[NB_T*2 + c])),
                              int'($signed(mvs[NB_TR*2 + c])),
                              int'($signed(mvs[NB_TL*2 + c]))));
    end
  end
endmodule

// File: rtl/pfp_win_axis.sv
module pfp_win_axis
  import pfp_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int NBLK  = 8,
  parameter int LCU   = 64,
  parameter int RANGE = 64,
  parameter int MV_W  = 10,
  parameter int OUT_W = 9
) (
  input  logic [IDX_W-1:0] blk,
  input  logic [MV_W-1:0]  center,
  output logic [OUT_W-1:0] corner
);
  localparam int WIN  = LCU + 2 * RANGE;
  localparam int HI   = NBLK * LCU - WIN;

  int raw;
  always_comb begin
    raw    = int'(blk) * LCU + int'($signed(center)) - RANGE;
    corner = OUT_W'(pfp_clamp(raw, 0, HI));
  end
endmodule

// File: rtl/pfp_top.sv
module pfp_top
  import pfp_pkg::*;
#(
  parameter int MV_W  = 10,
  parameter int NCOLS = 8,
  parameter int NROWS = 6,
  parameter int LCU   = 64,
  parameter int RANGE = 64,
  parameter int COL_W = $clog2(NCOLS),
  parameter int ROW_W = $clog2(NROWS),
  parameter int XW    = $clog2(NCOLS * LCU),
  parameter int YW    = $clog2(NROWS * LCU)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tr_done,
  input  logic [COL_W-1:0]        cur_col,
  input  logic [ROW_W-1:0]        cur_row,
  input  logic [2:0]              nbr_avail,
  input  logic signed [MV_W-1:0]  t_mvx,
  input  logic signed [MV_W-1:0]  t_mvy,
  input  logic signed [MV_W-1:0]  tr_mvx,
  input  logic signed [MV_W-1:0]  tr_mvy,
  input  logic signed [MV_W-1:0]  tl_mvx,
  input  logic signed [MV_W-1:0]  tl_mvy,
  input  logic                    req_ready,
  output logic                    req_valid,
  output logic [XW-1:0]           req_x,
  output logic [YW-1:0]           req_y,
  output logic signed [MV_W-1:0]  ctr_x,
  output logic signed [MV_W-1:0]  ctr_y
);
  localparam int X_MAX = NCOLS * LCU - (LCU + 2 * RANGE);
  localparam int Y_MAX = NROWS * LCU - (LCU + 2 * RANGE);

  logic [5:0][MV_W-1:0] mvs;
  logic [2:0]           use_nb;
  logic [1:0][MV_W-1:0] sel;
  logic [XW-1:0]        win_x;
  logic [YW-1:0]        win_y;
  logic                 accept;

  assign mvs = {tl_mvy, tl_mvx, tr_mvy, tr_mvx, t_mvy, t_mvx};
  assign accept = tr_done && (!req_valid || req_ready);

  pfp_select #(.MV_W(MV_W), .COL_W(COL_W), .ROW_W(ROW_W), .NCOLS(NCOLS)) u_sel (
    .col(cur_col), .row(cur_row), .avail(nbr_avail), .mvs(mvs),
    .use_nb(use_nb), .sel(sel)
  );

  pfp_win_axis #(.IDX_W(COL_W), .NBLK(NCOLS), .LCU(LCU), .RANGE(RANGE),
                 .MV_W(MV_W), .OUT_W(XW)) u_wx (
    .blk(cur_col), .center(sel[0]), .corner(win_x)
  );

  pfp_win_axis #(.IDX_W(ROW_W), .NBLK(NROWS), .LCU(LCU), .RANGE(RANGE),
                 .MV_W(MV_W), .OUT_W(YW)) u_wy (
    .blk(cur_row), .center(sel[1]), .corner(win_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_x     <= '0;
      req_y     <= '0;
      ctr_x     <= '0;
      ctr_y     <= '0;
    end else if (accept) begin
      req_valid <= 1'b1;
      req_x     <= win_x;
      req_y     <= win_y;
      ctr_x     <= sel[0];
      ctr_y     <= sel[1];
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

  // R10
  p_reset_idle_r10: assert property (@(posedge clk) !rst_n |=> !req_valid);

  p_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tr_done && (!req_valid || req_ready) |=> req_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_x) && $stable(req_y)
                                && $stable(ctr_x) && $stable(ctr_y));

  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !tr_done |=> !req_valid);

  p_none_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && use_nb == 3'b000 |=> ctr_x == '0 && ctr_y == '0);

  p_row0_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cur_row == '0 |=> ctr_x == '0 && ctr_y == '0);

  p_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> int'(req_x) <= X_MAX && int'(req_y) <= Y_MAX);
endmodule

// File: tb/sim_pfp_top.sv
module sim_pfp_top;
  localparam int CLK_PERIOD = 10;
  localparam int MV_W  = 10;
  localparam int NCOLS = 8;
  localparam int NROWS = 6;
  localparam int LCU   = 64;
  localparam int RANGE = 64;
  localparam int XW    = 9;
  localparam int YW    = 9;
  localparam int XLIM  = NCOLS * LCU - LCU - 2 * RANGE;
  localparam int YLIM  = NROWS * LCU - LCU - 2 * RANGE;
  localparam int IW    = 2 * MV_W + XW + YW;

  logic clk = 0, rst_n = 0, tr_done = 0, req_ready = 1;
  logic [2:0] cur_col = 0, cur_row = 0, nbr_avail = 0;
  logic signed [MV_W-1:0] t_mvx = 0, t_mvy = 0, tr_mvx = 0, tr_mvy = 0, tl_mvx = 0, tl_mvy = 0;
  logic req_valid;
  logic [XW-1:0] req_x;
  logic [YW-1:0] req_y;
  logic signed [MV_W-1:0] ctr_x, ctr_y;

  int n_chk = 0, n_bad = 0;
  logic [IW-1:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfp_top #(.MV_W(MV_W), .NCOLS(NCOLS), .NROWS(NROWS), .LCU(LCU), .RANGE(RANGE)) u0 (
    .clk(clk), .rst_n(rst_n), .tr_done(tr_done), .cur_col(cur_col), .cur_row(cur_row),
    .nbr_avail(nbr_avail), .t_mvx(t_mvx), .t_mvy(t_mvy), .tr_mvx(tr_mvx), .tr_mvy(tr_mvy),
    .tl_mvx(tl_mvx), .tl_mvy(tl_mvy), .req_ready(req_ready), .req_valid(req_valid),
    .req_x(req_x), .req_y(req_y), .ctr_x(ctr_x), .ctr_y(ctr_y)
  );

  function automatic int mid3(int a, int b, int c);
    int s0 = a, s1 = b, s2 = c, tmp;
    if (s0 > s1) begin tmp = s0; s0 = s1; s1 = tmp; end
    if (s1 > s2) begin tmp = s1; s1 = s2; s2 = tmp; end
    if (s0 > s1) begin tmp = s0; s0 = s1; s1 = tmp; end
    return s1;
  endfunction

  function automatic logic [IW-1:0] model(int col, int row, logic [2:0] av,
      int tx, int ty, int rx, int ry, int lx, int ly);
    logic ut, ur, ul;
    int cx, cy, wx, wy, n;
    ut = av[0] && row != 0;
    ur = av[1] && row != 0 && col != NCOLS - 1;
    ul = av[2] && row != 0 && col != 0;
    n = int'(ut) + int'(ur) + int'(ul);
    if (n == 0) begin cx = 0; cy = 0; end
    else if (n == 3) begin cx = mid3(tx, rx, lx); cy = mid3(ty, ry, ly); end
    else if (ut) begin cx = tx; cy = ty; end
    else if (ur) begin cx = rx; cy = ry; end
    else begin cx = lx; cy = ly; end
    wx = col * LCU - RANGE + cx;
    wy = row * LCU - RANGE + cy;
    if (wx < 0) wx = 0; else if (wx > XLIM) wx = XLIM;
    if (wy < 0) wy = 0; else if (wy > YLIM) wy = YLIM;
    return {MV_W'(cx), MV_W'(cy), XW'(wx), YW'(wy)};
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send(string tag, int col, int row, logic [2:0] av,
      int tx, int ty, int rx, int ry, int lx, int ly, bit expect_req);
    @(posedge clk); #1;
    cur_col = 3'(col); cur_row = 3'(row); nbr_avail = av;
    t_mvx = MV_W'(tx); t_mvy = MV_W'(ty); tr_mvx = MV_W'(rx); tr_mvy = MV_W'(ry);
    tl_mvx = MV_W'(lx); tl_mvy = MV_W'(ly);
    tr_done = 1;
    if (expect_req) begin
      exp_q.push_back(model(col, row, av, tx, ty, rx, ry, lx, ly));
      tag_q.push_back(tag);
    end
    @(posedge clk); #1;
    tr_done = 0;
    check(req_valid == 1'b1, "R6", "req_valid after pulse", int'(req_valid), 1);
  endtask

  // monitor: compare at mid-cycle whenever a handshake is about to occur
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && !done) begin
      logic [IW-1:0] got, exp;
      string t;
      got = {ctr_x, ctr_y, req_x, req_y};
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected request", int'(req_x), -1);
      end else begin
        exp = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got[IW-1 -: MV_W] == exp[IW-1 -: MV_W], t, "ctr_x",
              int'($signed(got[IW-1 -: MV_W])), int'($signed(exp[IW-1 -: MV_W])));
        check(got[XW+YW +: MV_W] == exp[XW+YW +: MV_W], t, "ctr_y",
              int'($signed(got[XW+YW +: MV_W])), int'($signed(exp[XW+YW +: MV_W])));
        check(got[YW +: XW] == exp[YW +: XW], t, "req_x (R9)",
              int'(got[YW +: XW]), int'(exp[YW +: XW]));
        check(got[YW-1:0] == exp[YW-1:0], t, "req_y (R9)",
              int'(got[YW-1:0]), int'(exp[YW-1:0]));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [XW-1:0] hx;
    logic [YW-1:0] hy;
    logic signed [MV_W-1:0] hcx, hcy;
    repeat (3) @(posedge clk);
    #1;
    check(req_valid == 1'b0, "R10", "req_valid in reset", int'(req_valid), 0);
    rst_n = 1;
    @(posedge clk); #1;
    check(req_valid == 1'b0, "R10", "req_valid after reset", int'(req_valid), 0);

    send("R1", 3, 2, 3'b000, 11, 12, 13, 14, 15, 16, 1);
    send("R2", 3, 2, 3'b010, 5, 6, -17, 23, 8, 9, 1);
    send("R2", 4, 3, 3'b100, 5, 6, 7, 8, -40, -33, 1);
    send("R3", 2, 2, 3'b101, 21, -22, 30, 31, 40, 41, 1);
    send("R3", 2, 2, 3'b110, 21, -22, 30, 31, 40, 41, 1);
    send("R3", 5, 4, 3'b011, -3, 4, 30, 31, 40, 41, 1);
    send("R4", 3, 3, 3'b111, -5, 7, 20, -9, 3, -2, 1);
    send("R4", 4, 2, 3'b111, -60, -1, -10, -50, -30, 40, 1);
    send("R5", 3, 0, 3'b111, 10, 11, 12, 13, 14, 15, 1);
    send("R5", 0, 2, 3'b111, 9, 1, -20, -8, 5, 4, 1);
    send("R5", 7, 2, 3'b111, 9, 1, 50, 30, 5, 4, 1);
    send("R9", 0, 1, 3'b001, -30, -10, 0, 0, 0, 0, 1);
    send("R9", 7, 5, 3'b001, 60, 50, 0, 0, 0, 0, 1);
    send("R9", 6, 4, 3'b001, -100, 70, 0, 0, 0, 0, 1);

    // hold and ignore while back-pressured
    @(posedge clk); #1;
    req_ready = 0;
    send("R7", 2, 3, 3'b111, 1, 2, 3, 4, 5, 6, 1);
    hx = req_x; hy = req_y; hcx = ctr_x; hcy = ctr_y;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1;
      check(req_valid && req_x == hx && req_y == hy && ctr_x == hcx && ctr_y == hcy,
            "R7", "held request", int'(req_x), int'(hx));
    end
    send("R8", 5, 5, 3'b001, 40, 40, 0, 0, 0, 0, 0);
    check(req_x == hx && req_y == hy && ctr_x == hcx && ctr_y == hcy,
          "R8", "pending request after ignored pulse", int'(ctr_x), int'(hcx));
    @(posedge clk); #1;
    req_ready = 1;
    @(posedge clk); #1;
    check(req_valid == 1'b0, "R7", "req_valid after handshake", int'(req_valid), 0);
    repeat (3) @(posedge clk);
    #1;
    check(req_valid == 1'b0, "R8", "no late request", int'(req_valid), 0);
    check(exp_q.size() == 0, "R6", "expected queue drained", exp_q.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule